// File: doc/BRIEF.md
# Transmit Byte Queue with Refill Interrupt

This block sits between a host write port and a serial frame encoder. The host first declares how many payload bytes the next frame carries, then streams bytes into a 24-entry queue. The encoder takes bytes one at a time through a valid/ready handshake. The final byte of the declared count is marked as last. Either the first byte written or a direct start command begins a transmission; no separate go command exists.

When a payload is longer than the queue, the host cannot write it all at once. The block therefore raises an interrupt when the queue drains to three bytes while more payload is still due. The host refills the queue in response. A second interrupt marks the end of the frame. Four cause bits are kept in a status register that clears when read. The interrupt line is high whenever any cause bit is set.

Top module: `txq_top`

## Requirements
- R1: The queue holds 24 bytes. A data write while the queue is full is discarded and sets status bit 2 (overflow). Bytes already stored are not disturbed.
- R2: A length write loads a 16-bit count of bytes still owed. A length write on its own starts nothing: out_valid stays low and the status stays zero.
- R3: The first data write starts the transmission. out_valid is high on the next cycle, and bytes leave in the order they were written.
- R4: A start command pulse starts the transmission. If the queue is then empty while bytes are still owed, status bit 3 (underflow) is set.
- R5: out_last is high exactly on the byte that takes the owed count to zero. After that byte is taken, out_valid stays low.
- R6: Status bit 0 (low level) is set when the queue level has fallen from above 3 to 3 or below while the owed count is larger than the level. It is set once per such crossing and arms again only after the level rises above 3. A payload that fits in the queue never sets it.
- R7: Status bit 1 (end of transmit) is set on the second clock edge after the last byte is taken.
- R8: stat_data shows the status register. irq is high whenever any status bit is set. A status read clears the register, and irq is low on the following cycle when no new event occurred.
- R9: An event that occurs in the same cycle as a status read is kept in the register.
- R10: After reset, out_valid, out_last and irq are low and the status is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr | input | 1 | Load the owed byte count |
| len_data | input | 16 | Byte count for the next frame |
| dat_wr | input | 1 | Push one payload byte |
| dat_in | input | 8 | Payload byte |
| cmd_start | input | 1 | Direct start command strobe |
| out_data | output | 8 | Byte offered to the encoder |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | Offered byte is the final one of the frame |
| out_ready | input | 1 | Encoder takes the offered byte |
| irq | output | 1 | Interrupt, high while any cause bit is set |
| stat_rd | input | 1 | Status read strobe; clears the register |
| stat_data | output | 4 | Cause bits: 0 low level, 1 end, 2 overflow, 3 underflow |

## Verification
The embedded properties check four things on every cycle: the level bound, that a write to a full queue is discarded, that each kind of start takes effect at once, and that the length load is exact. They also check that nothing is offered after the last byte, that the low-level event fires only once per crossing, that a read clears the register, and that a colliding event survives the read. Other behaviour only shows up over whole transfers, so the bench's scenarios cover it. These scenarios check the byte order across host refills and how many low-level interrupts a long payload produces. They also check the exact cycle on which the end cause appears and which byte is discarded on overflow.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int CAUSE_W  = 4;
  localparam int C_LOW    = 0;
  localparam int C_END    = 1;
  localparam int C_OVF    = 2;
  localparam int C_UDF    = 3;

  // Low-level condition: armed, running, level at or below mark, more owed than held.
  function automatic logic low_hit(input logic armed, input logic running,
                                   input int unsigned level, input int unsigned owed,
                                   input int unsigned mark);
    return armed && running && (level <= mark) && (owed > level);
  endfunction

  // Next write or read pointer of a circular buffer of the given depth.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 24,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             ev_ovf
);
  import txq_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign ev_ovf  = push && full;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (level <= $past(level))); // R1
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_data,
  input  logic             dat_wr,
  input  logic             cmd_start,
  input  logic             q_empty,
  input  logic             out_ready,
  output logic             running,
  output logic [LEN_W-1:0] owed,
  output logic             out_valid,
  output logic             out_last,
  output logic             pop_fire,
  output logic             ev_end,
  output logic             ev_udf
);
  logic start_req;

  assign start_req = dat_wr || cmd_start;
  assign out_valid = running && (owed != '0) && !q_empty;
  assign out_last  = out_valid && (owed == LEN_W'(1));
  assign pop_fire  = out_valid && out_ready;
  assign ev_end    = running && (owed == '0);
  assign ev_udf    = running && (owed != '0) && q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      owed    <= '0;
    end else begin
      running <= (running && !ev_end) || start_req;
      if (len_wr)        owed <= len_data;
      else if (pop_fire) owed <= owed - 1'b1;
    end
  end

  AST_DATA_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !running) |=> running); // R3
  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !running) |=> running); // R4
  AST_LEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> (owed == $past(len_data))); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && out_last && !len_wr) |=> !out_valid); // R5
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int LVL_W    = 5,
  parameter int LEN_W    = 16,
  parameter int LOW_MARK = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LVL_W-1:0]           level,
  input  logic [LEN_W-1:0]           owed,
  input  logic                       running,
  input  logic                       ev_end,
  input  logic                       ev_ovf,
  input  logic                       ev_udf,
  input  logic                       stat_rd,
  output logic                       ev_low,
  output logic [txq_pkg::CAUSE_W-1:0] status,
  output logic                       irq
);
  import txq_pkg::*;

  logic               armed;
  logic [CAUSE_W-1:0] ev_vec;

  assign ev_low = low_hit(armed, running, int'(level), int'(owed), LOW_MARK);

  always_comb begin
    ev_vec        = '0;
    ev_vec[C_LOW] = ev_low;
    ev_vec[C_END] = ev_end;
    ev_vec[C_OVF] = ev_ovf;
    ev_vec[C_UDF] = ev_udf;
  end

  assign irq = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      status <= '0;
    end else begin
      armed  <= (int'(level) > LOW_MARK);
      status <= (stat_rd ? '0 : status) | ev_vec;
    end
  end

  AST_LOW_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_low |=> !ev_low); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (ev_vec == '0)) |=> (status == '0)); // R8
  AST_EVT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev_end) |=> status[C_END]); // R9
endmodule

// File: rtl/txq_top.sv
module txq_top #(
  parameter int DEPTH    = 24,
  parameter int W        = 8,
  parameter int LEN_W    = 16,
  parameter int LOW_MARK = 3,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        len_wr,
  input  logic [LEN_W-1:0]            len_data,
  input  logic                        dat_wr,
  input  logic [W-1:0]                dat_in,
  input  logic                        cmd_start,
  output logic [W-1:0]                out_data,
  output logic                        out_valid,
  output logic                        out_last,
  input  logic                        out_ready,
  output logic                        irq,
  input  logic                        stat_rd,
  output logic [txq_pkg::CAUSE_W-1:0] stat_data
);
  logic [LVL_W-1:0] level;
  logic [LEN_W-1:0] owed;
  logic             q_empty, q_full, running, pop_fire;
  logic             ev_end, ev_udf, ev_ovf, ev_low;

  txq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(dat_wr), .wdata(dat_in), .pop(pop_fire),
    .rdata(out_data), .level(level), .empty(q_empty), .full(q_full), .ev_ovf(ev_ovf)
  );

  txq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_data(len_data),
    .dat_wr(dat_wr), .cmd_start(cmd_start), .q_empty(q_empty), .out_ready(out_ready),
    .running(running), .owed(owed), .out_valid(out_valid), .out_last(out_last),
    .pop_fire(pop_fire), .ev_end(ev_end), .ev_udf(ev_udf)
  );

  txq_irq #(.LVL_W(LVL_W), .LEN_W(LEN_W), .LOW_MARK(LOW_MARK)) u_irq (
    .clk(clk), .rst_n(rst_n), .level(level), .owed(owed), .running(running),
    .ev_end(ev_end), .ev_ovf(ev_ovf), .ev_udf(ev_udf), .stat_rd(stat_rd),
    .ev_low(ev_low), .status(stat_data), .irq(irq)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && q_full) |=> stat_data[txq_pkg::C_OVF]); // R1
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !q_empty); // R1
  AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_low |=> stat_data[txq_pkg::C_LOW]); // R6
endmodule

// File: tb/tb_txq_top.sv
module tb_txq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0;
  logic [15:0] len_data = '0;
  logic        dat_wr = 1'b0;
  logic [7:0]  dat_in = '0;
  logic        cmd_start = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic        irq;
  logic        stat_rd = 1'b0;
  logic [3:0]  stat_data;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  txq_top dut (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_data(len_data), .dat_wr(dat_wr),
    .dat_in(dat_in), .cmd_start(cmd_start), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready), .irq(irq), .stat_rd(stat_rd),
    .stat_data(stat_data)
  );

  // Vector table: payload length, first byte value, expected low-level interrupts.
  localparam int NV = 4;
  localparam int unsigned V_LEN [NV] = '{5, 24, 40, 60};
  localparam int unsigned V_SEED[NV] = '{8'h10, 8'h40, 8'h80, 8'h03};
  localparam int unsigned V_LOWS[NV] = '{0, 0, 1, 2};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_len(input int unsigned n);
    len_wr = 1'b1; len_data = 16'(n);
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  task automatic wr_byte(input int unsigned b);
    dat_wr = 1'b1; dat_in = 8'(b);
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic rd_stat(output logic [3:0] s);
    s = stat_data;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [3:0] s;
    int written, consumed, lows, cyc, n;
    bit done;

    do_reset();
    // R10: reset state
    chk(!out_valid && !out_last, "R10 valid/last", int'(out_valid), 0);
    chk(!irq && stat_data == 4'b0, "R10 irq/status", int'(stat_data), 0);

    for (int v = 0; v < NV; v++) begin
      wr_len(V_LEN[v]);
      written = 0; consumed = 0; lows = 0; cyc = 0; done = 0;
      n = (V_LEN[v] < 24) ? int'(V_LEN[v]) : 24;
      for (int i = 0; i < n; i++) begin wr_byte(V_SEED[v] + written); written++; end
      while (!done && cyc < 5000) begin
        cyc++;
        if (irq) begin
          rd_stat(s);
          chk(s[3:2] == 2'b00, "R1/R4 no ovf/udf in table run", int'(s), int'(s & 4'b0011));
          if (s[0]) begin
            lows++;
            n = (int'(V_LEN[v]) - written < 21) ? int'(V_LEN[v]) - written : 21;
            for (int i = 0; i < n; i++) begin wr_byte(V_SEED[v] + written); written++; end
          end
          if (s[1]) begin
            done = 1;
            chk(irq == 1'b0, "R8 irq drops after read", int'(irq), 0);
          end
        end else if (out_valid) begin
          chk(out_data == 8'(V_SEED[v] + consumed), "R3 byte order", int'(out_data),
              int'(8'(V_SEED[v] + consumed)));
          chk(out_last == (consumed == int'(V_LEN[v]) - 1), "R5 last flag", int'(out_last),
              int'(consumed == int'(V_LEN[v]) - 1));
          out_ready = 1'b1;
          consumed++;
          @(negedge clk);
          out_ready = 1'b0;
        end else begin
          @(negedge clk);
        end
      end
      chk(done, "R7 end cause seen", int'(done), 1);
      chk(consumed == int'(V_LEN[v]), "R5 bytes taken", consumed, int'(V_LEN[v]));
      chk(lows == int'(V_LOWS[v]), "R6 low interrupt count", lows, int'(V_LOWS[v]));
    end

    // R7: exact timing of the end cause for a one-byte frame
    do_reset();
    wr_len(1);
    wr_byte(8'hA5);
    chk(out_valid && out_last, "R3 valid next cycle", int'({out_valid, out_last}), 3);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid, "R5 no valid after last", int'(out_valid), 0);
    chk(!irq, "R7 end not yet", int'(irq), 0);
    @(negedge clk);
    chk(irq && stat_data == 4'b0010, "R7 end cause", int'(stat_data), 2);

    // R1: overflow drops the 25th byte
    do_reset();
    wr_len(30);
    for (int i = 0; i < 25; i++) wr_byte(i);
    chk(stat_data[2] == 1'b1, "R1 overflow bit", int'(stat_data), 4);
    consumed = 0;
    while (out_valid && consumed < 40) begin
      chk(out_data == 8'(consumed), "R1 stored bytes intact", int'(out_data), consumed);
      out_ready = 1'b1;
      consumed++;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(consumed == 24, "R1 depth 24", consumed, 24);

    // R2, R4, R9: length alone starts nothing; start command with empty queue underflows
    do_reset();
    wr_len(3);
    repeat (3) @(negedge clk);
    chk(!out_valid && stat_data == 4'b0, "R2 length write idle", int'(stat_data), 0);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    @(negedge clk);
    chk(stat_data == 4'b1000, "R4 underflow after start", int'(stat_data), 8);
    rd_stat(s);
    chk(stat_data == 4'b1000, "R9 event kept through read", int'(stat_data), 8);
    wr_byte(8'h77);
    chk(out_valid && out_data == 8'h77, "R4 started run offers byte", int'(out_data), 8'h77);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule